// File: doc/BRIEF.md
# SPI Memory Read Sequencer

This block is the serial front end of a byte-wide memory. It acts as the slave on a four-wire SPI link in mode 0. Once the select line goes low, it collects an 8-bit command and then a 16-bit byte address from the master. If the command is the read command, the block streams memory bytes back on the data-out line. Each byte is fetched through a synchronous read port that has one cycle of latency. Any other command makes the block stay silent until the select line rises again.

The whole block runs on one system clock. All four SPI wires are resynchronised into that clock, and the SPI clock edges are detected from the resynchronised samples. The byte address advances after every byte, and it wraps from the top of the array to zero. A master can therefore read any length of data, up to the whole array and beyond, in a single selected period. The next byte is fetched while the current one is still shifting out, so no idle bits appear between bytes. The data-out line is driven only through an output enable, and the enable is asserted only during the data phase.

Top module: `spi_rd_seq`

## Requirements
- R1: After reset, and whenever the select line has been high for the synchroniser latency, spi_miso_oe is 0 and mem_re is 0.
- R2: spi_mosi is captured on rising edges of spi_clk. spi_miso changes only after falling edges of spi_clk and holds its value while spi_clk is high.
- R3: The read command is 0x03, sent MSB first. It is followed by a 16-bit address, bit 15 first. The first memory read uses the low ADDR_W bits of that address, and the upper bits are discarded.
- R4: If the command is not 0x03, spi_miso_oe stays 0 and no memory read is issued until the select line rises.
- R5: spi_miso_oe is 0 during the command and address bits. It becomes 1 on the first spi_clk falling edge after the 16th address bit and stays 1 until the select line rises.
- R6: Each data byte is sent MSB first, one bit per spi_clk falling edge. spi_mosi has no effect during the data phase.
- R7: Successive bytes come from successive addresses. After address 2^ADDR_W-1 the next byte comes from address 0.
- R8: Each memory read is a single-cycle mem_re pulse. The read for the following byte is issued when a byte starts shifting out, so bytes follow one another with no gap. After n whole bytes have been clocked out, n+2 reads have been issued.
- R9: Raising the select line ends the transaction at any bit. The next selected period starts again with a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the master, idles low (mode 0) |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for spi_miso (1 = drive) |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 64-byte array. With that size, the wrap from address 63 to 0 is reached within a few bytes, and a single transaction can stream the whole array more than once. It also sends addresses with nonzero upper bits, so it shows that those bits are discarded. The synchroniser depth is left at 2, and the SPI clock runs at one twentieth of the system clock. At that ratio the prefetch must land between two SPI edges, which puts the no-gap path under test at a realistic margin.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;
  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned ADR_BITS = 16;
endpackage

// File: rtl/spi_rd_sync.sv
`timescale 1ns/1ps
module spi_rd_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : stg
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= stg[g-1].r;
      end
    end
  end

  assign q = stg[STAGES-1].r;
endmodule

// File: rtl/spi_rd_rx.sv
`timescale 1ns/1ps
module spi_rd_rx
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              in_data
);
  localparam logic [3:0] CMD_LAST = 4'(CMD_BITS - 1);
  localparam logic [3:0] ADR_LAST = 4'(ADR_BITS - 1);

  phase_t            phase;
  logic [3:0]        cnt;
  logic [6:0]        op_q;
  logic [ADDR_W-1:0] adr_q;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase <= PH_CMD;
      cnt   <= '0;
      start <= 1'b0;
      op_q  <= '0;
    end else begin
      start <= 1'b0;
      if (sck_rise) begin
        unique case (phase)
          PH_CMD: begin
            op_q <= {op_q[5:0], mosi};
            if (cnt == CMD_LAST) begin
              cnt   <= '0;
              phase <= ({op_q, mosi} == RD_OPCODE) ? PH_ADDR : PH_SKIP;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
          PH_ADDR: begin
            // bits above the array width fall off the top of the register
            adr_q <= {adr_q[ADDR_W-2:0], mosi};
            if (cnt == ADR_LAST) begin
              cnt   <= '0;
              phase <= PH_DATA;
              start <= 1'b1;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign start_addr = adr_q;
  assign in_data    = (phase == PH_DATA);
endmodule

// File: rtl/spi_rd_tx.sv
`timescale 1ns/1ps
module spi_rd_tx #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_data,
  input  logic [7:0]        mem_rdata,
  output logic              so,
  output logic              so_oe,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr
);
  logic       cap_q;
  logic [7:0] nxt_q;
  logic [6:0] sh_q;
  logic [2:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      mem_re <= 1'b0;
      cap_q  <= 1'b0;
      so_oe  <= 1'b0;
      so     <= 1'b0;
      bcnt   <= '0;
    end else begin
      mem_re <= 1'b0;
      cap_q  <= mem_re;
      if (cap_q) nxt_q <= mem_rdata;
      if (start) begin
        mem_addr <= start_addr;
        mem_re   <= 1'b1;
      end else if (in_data && sck_fall) begin
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd0) begin
          // load prefetched byte and fetch the one after it
          so       <= nxt_q[7];
          sh_q     <= nxt_q[6:0];
          so_oe    <= 1'b1;
          mem_addr <= mem_addr + 1'b1;
          mem_re   <= 1'b1;
        end else begin
          so   <= sh_q[6];
          sh_q <= {sh_q[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rd_seq.sv
`timescale 1ns/1ps
module spi_rd_seq #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_clk,
  input  logic              spi_sel_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  logic sel_s, sck_s, mosi_s, sck_d;
  logic cs_act, sck_rise, sck_fall;
  logic rx_start, in_data;
  logic [ADDR_W-1:0] rx_addr;

  spi_rd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sel_n, spi_clk, spi_mosi}),
    .q   ({sel_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign cs_act   = ~sel_s;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  spi_rd_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .mosi       (mosi_s),
    .start      (rx_start),
    .start_addr (rx_addr),
    .in_data    (in_data)
  );

  spi_rd_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .sck_fall   (sck_fall),
    .start      (rx_start),
    .start_addr (rx_addr),
    .in_data    (in_data),
    .mem_rdata  (mem_rdata),
    .so         (spi_miso),
    .so_oe      (spi_miso_oe),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr)
  );
endmodule

// File: rtl/spi_rd_chk.sv
`timescale 1ns/1ps
module spi_rd_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              rx_start,
  input logic              in_data,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!spi_miso_oe && !mem_re));

  assert_miso_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sck_fall) |=> $stable(spi_miso));

  assert_first_read_R3: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> mem_re);

  assert_oe_data_only_R5: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> in_data);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_re && !$past(rx_start)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_read_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
endmodule

bind spi_rd_seq spi_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_act      (cs_act),
  .sck_fall    (sck_fall),
  .rx_start    (rx_start),
  .in_data     (in_data),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .mem_re      (mem_re),
  .mem_addr    (mem_addr)
);

// File: tb/sim_spi_rd_seq.sv
`timescale 1ns/1ps
module sim_spi_rd_seq;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  wire miso, miso_oe, mem_re;
  wire [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  int exp_rd = 0, rd_cnt = 0, hi_cnt = 0;
  bit rd_ok = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_rd_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .spi_clk(sck), .spi_sel_n(sel_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // memory model: one-cycle synchronous read
  always @(posedge clk) if (mem_re) mem_rdata <= pat(int'(mem_addr));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison of read strobes and idle outputs
  always @(negedge clk) begin
    if (!rst && !done) begin
      hi_cnt = sel_n ? hi_cnt + 1 : 0;
      if (mem_re) begin
        if (!rd_ok) chk(1'b0, "R4 read strobe outside a read", 1, 0);
        else begin
          chk(int'(mem_addr) == exp_rd, "R3/R7 read address", int'(mem_addr), exp_rd);
          exp_rd = (exp_rd + 1) % DEPTH;
          rd_cnt++;
        end
      end
      if (hi_cnt >= 4) begin
        chk(miso_oe == 1'b0, "R1/R9 oe while deselected", miso_oe, 0);
        chk(mem_re == 1'b0, "R1 read while deselected", mem_re, 0);
      end
    end
  end

  task automatic clkw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input bit b, output bit r, output bit oe);
    mosi = b;
    clkw(HALF);
    r  = miso;
    oe = miso_oe;
    sck = 1'b1;
    clkw(HALF);
    chk(miso == r, "R2 miso held while clock high", miso, r);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    bit r, oe;
    for (int i = n - 1; i >= 0; i--) begin
      xbit(v[i], r, oe);
      chk(oe == 1'b0, "R5 oe low in command/address", oe, 0);
    end
  endtask

  task automatic begin_read(input logic [15:0] ad);
    rd_ok  = 1'b1;
    rd_cnt = 0;
    exp_rd = int'(ad) % DEPTH;
    sel_n  = 1'b0;
    clkw(HALF);
    send_bits(16'h0003, 8);
    send_bits(ad, 16);
  endtask

  task automatic read_bytes(input int first, input int n);
    bit r, oe;
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        xbit(~i[0], r, oe);   // noise on mosi: R6 says it is ignored
        chk(oe == 1'b1, "R5 oe high in data phase", oe, 1);
        b[i] = r;
      end
      chk(b == pat((first + k) % DEPTH), "R6/R7 data byte", b, pat((first + k) % DEPTH));
    end
  endtask

  task automatic end_tx();
    clkw(HALF);
    sel_n = 1'b1;
    clkw(3 * HALF);
    rd_ok = 1'b0;
  endtask

  initial begin
    bit r, oe;
    clkw(5);
    rst = 1'b0;
    clkw(2);
    chk(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
    chk(mem_re == 1'b0, "R1 read after reset", mem_re, 0);

    // plain read, R3 R6 R8
    begin_read(16'h0005);
    read_bytes(5, 4);
    clkw(HALF);
    chk(rd_cnt == 6, "R8 read count after 4 bytes", rd_cnt, 6);
    end_tx();

    // upper address bits discarded and wrap, R3 R7
    begin_read(16'hFFFC);
    read_bytes(60, 8);
    end_tx();

    // non-read command, R4
    rd_ok = 1'b0;
    sel_n = 1'b0;
    clkw(HALF);
    send_bits(16'h000B, 8);
    send_bits(16'h0012, 16);
    for (int i = 0; i < 16; i++) begin
      xbit(1'b1, r, oe);
      chk(oe == 1'b0, "R4 oe stays low after other command", oe, 0);
    end
    end_tx();

    // abort inside the address, then fresh read, R9
    sel_n = 1'b0;
    clkw(HALF);
    send_bits(16'h0003, 8);
    send_bits(16'h0015, 5);
    end_tx();
    chk(miso_oe == 1'b0, "R9 oe after address abort", miso_oe, 0);
    begin_read(16'h0010);
    read_bytes(16, 2);
    end_tx();

    // abort inside a data byte, then read across the top, R9 R7
    begin_read(16'h0020);
    read_bytes(32, 1);
    for (int i = 0; i < 3; i++) xbit(1'b0, r, oe);
    end_tx();
    chk(miso_oe == 1'b0, "R9 oe after data abort", miso_oe, 0);
    begin_read(16'h403F);
    read_bytes(63, 3);
    end_tx();

    // stream more than the whole array, R7 R8
    begin_read(16'h0000);
    read_bytes(0, DEPTH + 2);
    clkw(HALF);
    chk(rd_cnt == DEPTH + 4, "R8 read count full stream", rd_cnt, DEPTH + 4);
    end_tx();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule